// File: doc/BRIEF.md
# Boot Memory Block-Switch Controller

This block owns the two-bit code-map register that decides which physical flash block answers fetches in the low 8 KB of logical code space. Each time reset is held, the register is reloaded from two non-volatile start-up bits. The rule used for the reload depends on why the chip was reset.

Once the chip is running, software may flip the low bit of the register to swap the low window live. The two start-up bits are read-only inputs here, so flipping the low bit never touches them.

A combinational remapper turns each logical fetch address into a physical address. A registered flag marks any write to the low bit that happens while the fetch address lies inside the window being swapped.

Top module: `bootmap_ctrl`

## Requirements
- R1: While `rst_n` is low and `rst_cause` is 2'b00 (power-on or external), each clock edge loads `map_cfg` with {~`nv_sc1`, ~`nv_sc0`}. A start-up bit reads 0 when programmed and 1 when unprogrammed, so both unprogrammed gives the default 2'b00.
- R2: While `rst_n` is low and `rst_cause` is 2'b01 (watchdog or brown-out), each edge keeps `map_cfg[1]` and loads `map_cfg[0]` with ~`nv_sc0`.
- R3: While `rst_n` is low and `rst_cause` is 2'b10 (software), each edge loads `map_cfg` with {1, ~`nv_sc0`}, which is 2'b10 or 2'b11.
- R4: While `rst_n` is low and `rst_cause` is 2'b11 (no cause), `map_cfg` keeps both bits.
- R5: With `rst_n` high, a clock edge with `wr_en` high loads `map_cfg[0]` from `wr_bit` and leaves `map_cfg[1]` as it was. While `rst_n` is low, `wr_en` has no effect.
- R6: With `rst_n` high and `wr_en` low, `map_cfg` holds its value whatever `nv_sc1` and `nv_sc0` do.
- R7: When `map_cfg[0]` is 1 and `fetch_addr` is below 16'h2000, `phys_addr` equals `fetch_addr` + 17'h10000, in the same cycle.
- R8: When `map_cfg[0]` is 0, or `fetch_addr` is 16'h2000 or above, `phys_addr` equals `fetch_addr` zero-extended to 17 bits.
- R9: `swap_hazard` is high for exactly the cycle after an accepted write (R5) whose `fetch_addr` was below 16'h2000. It is low after any other cycle, and low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reload happens while low |
| rst_cause | input | 2 | Reset cause: 00 power/external, 01 watchdog/brown-out, 10 software, 11 none |
| nv_sc1 | input | 1 | Start-up bit for the high register bit (0 = programmed) |
| nv_sc0 | input | 1 | Start-up bit for the low register bit (0 = programmed) |
| wr_en | input | 1 | Software write strobe for the low register bit |
| wr_bit | input | 1 | Value written to the low register bit |
| fetch_addr | input | 16 | Logical code fetch address |
| map_cfg | output | 2 | Current code-map register |
| phys_addr | output | 17 | Physical fetch address after remapping |
| swap_hazard | output | 1 | Write to the low bit happened while fetching inside the swapped window |

## Verification
The register, and with it `map_cfg`, changes one clock edge after a reset cycle or an accepted write. `swap_hazard` also rises one edge after the write that causes it, and falls at the following edge. `phys_addr` follows `fetch_addr` and `map_cfg` with no clock in between.

Inputs are driven on the falling edge. After the single rising edge that takes them, the registered results are sampled at the next falling edge. The address results are sampled one time unit after the address is driven, with no clock edge in between.

The watchdog case is run after power-on reloads that left the high bit set and then clear. This shows the high bit is held in both states and not reloaded.

// File: rtl/bootmap_pkg.sv
// Package: shared reset-cause encoding for the boot block-switch controller.
// Assumes the cause code is stable while reset is held.
package bootmap_pkg;
    localparam logic [1:0] CAUSE_PWR  = 2'b00;  // power-on or external pin
    localparam logic [1:0] CAUSE_WDOG = 2'b01;  // watchdog or brown-out
    localparam logic [1:0] CAUSE_SOFT = 2'b10;  // software-requested
    localparam logic [1:0] CAUSE_NONE = 2'b11;  // no reload
endpackage

// File: rtl/bootmap_cfg_reg.sv
// Module: two-bit code-map register with cause-dependent reload.
// While rst_n is low it reloads on every edge according to cause; afterwards
// only bit 0 is writable. Start-up bits read 0 when programmed.
module bootmap_cfg_reg
    import bootmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cause,
    input  logic       nv_sc1,
    input  logic       nv_sc0,
    input  logic       wr_en,
    input  logic       wr_bit,
    output logic [1:0] cfg
);
    // Reload under reset by cause, else accept software writes to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            case (cause)
                CAUSE_PWR:  cfg <= {~nv_sc1, ~nv_sc0};
                CAUSE_WDOG: cfg <= {cfg[1], ~nv_sc0};
                CAUSE_SOFT: cfg <= {1'b1, ~nv_sc0};
                default:    cfg <= cfg;
            endcase
        end else if (wr_en) begin
            cfg[0] <= wr_bit;
        end
    end
endmodule

// File: rtl/bootmap_remap.sv
// Module: logical-to-physical fetch address translation.
// Addresses inside the low window of 2**WIN_BITS bytes gain ALT_BASE when
// swap is set; all others are zero-extended. Assumes PHYS_W > ADDR_W.
module bootmap_remap #(
    parameter int ADDR_W   = 16,
    parameter int PHYS_W   = 17,
    parameter int WIN_BITS = 13,
    parameter logic [PHYS_W-1:0] ALT_BASE = 17'h10000
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              swap,
    output logic              in_win,
    output logic [PHYS_W-1:0] phys_addr
);
    localparam int EXT_W = PHYS_W - ADDR_W;

    logic [PHYS_W-1:0] addr_ext;

    // Window detect: variant chosen by whether the window covers everything.
    generate
        if (WIN_BITS >= ADDR_W) begin : g_full_win
            assign in_win = 1'b1;
        end else begin : g_part_win
            assign in_win = (fetch_addr[ADDR_W-1:WIN_BITS] == '0);
        end
    endgenerate

    // Select relocated or pass-through physical address.
    always_comb begin
        addr_ext  = {{EXT_W{1'b0}}, fetch_addr};
        phys_addr = (swap && in_win) ? (addr_ext + ALT_BASE) : addr_ext;
    end
endmodule

// File: rtl/bootmap_hazard.sv
// Module: registered flag for a bit-0 write while fetching in the window.
// Assumes wr_en already reflects an accepted write (reset excluded upstream).
module bootmap_hazard (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic in_win,
    output logic hazard
);
    // One-cycle pulse after a write that overlaps the swapped window.
    always_ff @(posedge clk) begin
        if (!rst_n) hazard <= 1'b0;
        else        hazard <= wr_en && in_win;
    end
endmodule

// File: rtl/bootmap_ctrl.sv
// Module: top of the boot block-switch controller.
// Holds the code-map register, remaps fetch addresses through bit 0 and
// flags live swaps that hit the active window. Synchronous active-low reset.
module bootmap_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int PHYS_W   = 17,
    parameter int WIN_BITS = 13,
    parameter logic [PHYS_W-1:0] ALT_BASE = 17'h10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rst_cause,
    input  logic              nv_sc1,
    input  logic              nv_sc0,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        map_cfg,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              swap_hazard
);
    logic in_win;

    bootmap_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cause  (rst_cause),
        .nv_sc1 (nv_sc1),
        .nv_sc0 (nv_sc0),
        .wr_en  (wr_en),
        .wr_bit (wr_bit),
        .cfg    (map_cfg)
    );

    bootmap_remap #(
        .ADDR_W   (ADDR_W),
        .PHYS_W   (PHYS_W),
        .WIN_BITS (WIN_BITS),
        .ALT_BASE (ALT_BASE)
    ) u_remap (
        .fetch_addr (fetch_addr),
        .swap       (map_cfg[0]),
        .in_win     (in_win),
        .phys_addr  (phys_addr)
    );

    bootmap_hazard u_hz (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .in_win (in_win),
        .hazard (swap_hazard)
    );
endmodule

// File: rtl/bootmap_chk.sv
// Module: assertion checker for bootmap_ctrl, attached by bind below.
// Observes ports only.
module bootmap_chk #(
    parameter int ADDR_W   = 16,
    parameter int PHYS_W   = 17,
    parameter int WIN_BITS = 13,
    parameter logic [PHYS_W-1:0] ALT_BASE = 17'h10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rst_cause,
    input logic              nv_sc1,
    input logic              nv_sc0,
    input logic              wr_en,
    input logic              wr_bit,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [1:0]        map_cfg,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              swap_hazard
);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(1) << WIN_BITS;

    // R1
    por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && $past(rst_cause) == 2'b00)
            |-> map_cfg == {~$past(nv_sc1), ~$past(nv_sc0)});

    // R3
    soft_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && $past(rst_cause) == 2'b10)
            |-> map_cfg == {1'b1, ~$past(nv_sc0)});

    // R5
    wr_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_cfg[0] == $past(wr_bit)) && (map_cfg[1] == $past(map_cfg[1])));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(map_cfg));

    // R7
    relocate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_cfg[0] && fetch_addr < WIN_END)
            |-> phys_addr == PHYS_W'(fetch_addr) + ALT_BASE);

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_cfg[0] || fetch_addr >= WIN_END) |-> phys_addr == PHYS_W'(fetch_addr));

    // R9
    hazard_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fetch_addr < WIN_END) |=> swap_hazard);

    // R9
    hazard_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_hazard |-> ($past(wr_en) && $past(fetch_addr) < WIN_END && $past(rst_n)));
endmodule

bind bootmap_ctrl bootmap_chk #(
    .ADDR_W   (ADDR_W),
    .PHYS_W   (PHYS_W),
    .WIN_BITS (WIN_BITS),
    .ALT_BASE (ALT_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_cause   (rst_cause),
    .nv_sc1      (nv_sc1),
    .nv_sc0      (nv_sc0),
    .wr_en       (wr_en),
    .wr_bit      (wr_bit),
    .fetch_addr  (fetch_addr),
    .map_cfg     (map_cfg),
    .phys_addr   (phys_addr),
    .swap_hazard (swap_hazard)
);

// File: tb/tb_bootmap_ctrl.sv
// Directed bench for bootmap_ctrl; one task per scenario.
`timescale 1ns/1ps
module tb_bootmap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rst_cause = 2'b00;
    logic        nv_sc1 = 1'b1;
    logic        nv_sc0 = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_bit = 1'b0;
    logic [15:0] fetch_addr = 16'h0000;
    logic [1:0]  map_cfg;
    logic [16:0] phys_addr;
    logic        swap_hazard;

    int checks = 0;
    int errors = 0;

    bootmap_ctrl dut (
        .clk (clk), .rst_n (rst_n), .rst_cause (rst_cause),
        .nv_sc1 (nv_sc1), .nv_sc0 (nv_sc0), .wr_en (wr_en), .wr_bit (wr_bit),
        .fetch_addr (fetch_addr), .map_cfg (map_cfg), .phys_addr (phys_addr),
        .swap_hazard (swap_hazard)
    );

    always #5 clk = ~clk;

    // Watchdog: count a failure and still print the summary.
    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Hold reset for n edges with the given cause and start-up bits, then release.
    task automatic apply_reset(input logic [1:0] cause, input logic s1, input logic s0, input int n);
        @(negedge clk);
        rst_n = 1'b0; rst_cause = cause; nv_sc1 = s1; nv_sc0 = s0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1; rst_cause = 2'b11;
    endtask

    task automatic sw_write(input logic b, input logic [15:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_bit = b; fetch_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_por();
        for (int k = 0; k < 4; k++) begin
            apply_reset(2'b00, k[1], k[0], 2);
            check("R1 power-on load", map_cfg, {~k[1], ~k[0]});
        end
        apply_reset(2'b00, 1'b1, 1'b1, 1);
        check("R1 default 00", map_cfg, 2'b00);
        check("R9 hazard low after reset", swap_hazard, 1'b0);
    endtask

    task automatic t_wdog();
        apply_reset(2'b00, 1'b0, 1'b1, 1);        // cfg = 10
        apply_reset(2'b01, 1'b1, 1'b0, 3);        // bit1 held 1, bit0 = 1
        check("R2 watchdog keeps bit1=1", map_cfg, 2'b11);
        apply_reset(2'b00, 1'b1, 1'b0, 1);        // cfg = 01
        apply_reset(2'b01, 1'b0, 1'b1, 2);        // bit1 held 0, bit0 = 0
        check("R2 watchdog keeps bit1=0", map_cfg, 2'b00);
    endtask

    task automatic t_soft();
        apply_reset(2'b00, 1'b1, 1'b1, 1);
        apply_reset(2'b10, 1'b1, 1'b1, 1);
        check("R3 software reset 10", map_cfg, 2'b10);
        apply_reset(2'b10, 1'b1, 1'b0, 1);
        check("R3 software reset 11", map_cfg, 2'b11);
    endtask

    task automatic t_none();
        apply_reset(2'b00, 1'b0, 1'b1, 1);        // cfg = 10
        sw_write(1'b1, 16'h4000);                 // cfg = 11
        apply_reset(2'b11, 1'b1, 1'b1, 2);
        check("R4 no-cause reset holds", map_cfg, 2'b11);
    endtask

    task automatic t_write();
        apply_reset(2'b00, 1'b0, 1'b1, 1);        // cfg = 10
        sw_write(1'b1, 16'h8000);
        check("R5 write bit0=1 keeps bit1", map_cfg, 2'b11);
        sw_write(1'b0, 16'h8000);
        check("R5 write bit0=0 keeps bit1", map_cfg, 2'b10);
        // write attempt while reset held with no cause
        @(negedge clk);
        rst_n = 1'b0; rst_cause = 2'b11; wr_en = 1'b1; wr_bit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b1;
        check("R5 write ignored in reset", map_cfg, 2'b10);
    endtask

    task automatic t_nv_change();
        apply_reset(2'b00, 1'b1, 1'b0, 1);        // cfg = 01
        @(negedge clk);
        nv_sc1 = 1'b0; nv_sc0 = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 start-up bits ignored when running", map_cfg, 2'b01);
    endtask

    task automatic t_remap();
        apply_reset(2'b00, 1'b1, 1'b1, 1);        // bit0 = 0
        fetch_addr = 16'h0000; #1;
        check("R8 low addr no swap", phys_addr, 17'h00000);
        fetch_addr = 16'h1FFF; #1;
        check("R8 window top no swap", phys_addr, 17'h01FFF);
        sw_write(1'b1, 16'h9000);
        fetch_addr = 16'h0000; #1;
        check("R7 window base swapped", phys_addr, 17'h10000);
        fetch_addr = 16'h1FFF; #1;
        check("R7 window top swapped", phys_addr, 17'h11FFF);
        fetch_addr = 16'h2000; #1;
        check("R8 just above window", phys_addr, 17'h02000);
        fetch_addr = 16'hFFFF; #1;
        check("R8 top of space", phys_addr, 17'h0FFFF);
    endtask

    task automatic t_hazard();
        apply_reset(2'b00, 1'b1, 1'b1, 1);
        sw_write(1'b1, 16'h1000);
        check("R9 hazard after in-window write", swap_hazard, 1'b1);
        @(negedge clk);
        check("R9 hazard single cycle", swap_hazard, 1'b0);
        sw_write(1'b0, 16'h3000);
        check("R9 no hazard outside window", swap_hazard, 1'b0);
        sw_write(1'b1, 16'h1FFF);
        check("R9 hazard at window top", swap_hazard, 1'b1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_por();
        t_wdog();
        t_soft();
        t_none();
        t_write();
        t_nv_change();
        t_remap();
        t_hazard();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule